// File: doc/BRIEF.md
# Multi-Output Raster Timing Generator

This block produces the raster timing for a display pipe. A pixel counter and a line counter run freely from two programmed lengths: one line length in clock cycles and one field length in half-lines. A progressive frame is programmed as twice its line count. The block drives the current pixel and line coordinates and the field parity. It also drives an active-video flag and four independent horizontal/vertical sync pairs. Each sync pair has its own edge positions, so that downstream paths with different pipeline latencies can each get syncs that line up with their own delay.

Software programs the block through a word-addressed register bus. Every setting goes into a pending bank, which can be read back at once. The pending bank is copied into the working bank only when a field begins, or when the restart register is written. Top and bottom fields have separate window and vsync words, and the two fields alternate. Two field events, top and bottom, set sticky status bits. The status bits are cleared by writing one. The mask is changed through separate set and clear addresses, and the interrupt output is the OR of the status bits that are enabled.

Register word addresses: 0 mode (0 = free-running, anything else holds the counters), 1 clocks per line, 2 half-lines per field, 3 restart, 4/5 top window start/stop, 6/7 bottom window start/stop, 8 status, 9 status clear, 10 mask read and mask clear, 11 mask set. Sync output n (0..3) has its words at 16+8n: +0 horizontal, +1 top vsync line, +2 bottom vsync line, +3 top vsync offset, +4 bottom vsync offset.

Top module: `vtiming_gen`

## Requirements
- R1: The pixel counter (pix_o) runs from 0 to L-1, where L is the value at address 1, and then returns to 0 while the line counter advances. Line numbering starts at 1. Reset leaves pixel 0, line 1, top field.
- R2: The number of lines per field is the value at address 2 divided by two. After the last pixel of the last line, the counters return to pixel 0, line 1 and the field flips between top (bot_field_o = 0) and bottom (bot_field_o = 1).
- R3: active_o is high when the line lies within the start and stop line numbers and the pixel lies within the start and stop pixel numbers, both bounds inclusive. Each window word holds the line in bits 31:16 and the pixel in bits 15:0. The top-field pair is at 4/5 and the bottom-field pair at 6/7.
- R4: hsync_o[n] is high for start <= pixel < stop. The horizontal word holds the stop sample in bits 31:16 and the start sample in bits 15:0. Equal values give no pulse.
- R5: When the stop sample is below the start sample, hsync_o[n] wraps past the end of the line: it is high for pixel >= start or pixel < stop.
- R6: vsync_o[n] rises at the (line, pixel) position made of the low halves of the line word and the offset word. It falls at the position made of the high halves. When the fall position comes before the rise position, the pulse wraps across the field boundary.
- R7: The vsync line and offset words are chosen by the current field: top words (+1, +3) in the top field, bottom words (+2, +4) in the bottom field.
- R8: Status bit 1 is set on the first clock of a top field and bit 0 on the first clock of a bottom field. Writing ones to address 9 clears those bits. If a clear and an event land in the same cycle, the event wins.
- R9: Writing ones to address 11 sets mask bits and writing ones to address 10 clears them. irq_o is high when any status bit and its mask bit are both 1.
- R10: Writing 1 in bit 0 to address 3 restarts the counters at pixel 0, line 1, top field, and loads the pending settings.
- R11: A configuration write can be read back at once but only takes effect at the next field start or restart.
- R12: A non-zero mode holds the counters still. A zero mode lets them run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pix_o | output | PIX_W | Current pixel number |
| line_o | output | LIN_W | Current line number |
| bot_field_o | output | 1 | High during a bottom field |
| active_o | output | 1 | Active-video window flag |
| hsync_o | output | N_SYNC | Horizontal sync per output |
| vsync_o | output | N_SYNC | Vertical sync per output |
| irq_o | output | 1 | Masked field-event interrupt |

## Verification
The bench scans two full fields cycle by cycle with outputs that differ per field. It includes one hsync that wraps and one that covers only the last pixel, and one vsync whose rise sits on the last line and whose fall sits on the first line. A design that compared these positions without wrapping would miss those pulses entirely. The bench rewrites the line length in the middle of a field and checks that the old length holds until the field ends; a design without shadowing would cut the line short at once. It issues a status clear in exactly the cycle of a field event; a design that lets the clear win would lose that event. A halt test checks that a mode change waits for the field start and then freezes the counters.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   localparam int A_MODE      = 0;
   localparam int A_LINE_LEN  = 1;
   localparam int A_FIELD_HL  = 2;
   localparam int A_RESTART   = 3;
   localparam int A_WIN_T_ST  = 4;
   localparam int A_WIN_T_SP  = 5;
   localparam int A_WIN_B_ST  = 6;
   localparam int A_WIN_B_SP  = 7;
   localparam int A_STAT      = 8;
   localparam int A_STAT_CLR  = 9;
   localparam int A_MASK_CLR  = 10;
   localparam int A_MASK_SET  = 11;
   localparam int A_SYNC_BASE = 16;
   localparam int SYNC_STRIDE = 8;

   localparam int S_HORZ = 0;
   localparam int S_VL_T = 1;
   localparam int S_VL_B = 2;
   localparam int S_VO_T = 3;
   localparam int S_VO_B = 4;

   localparam int EV_BOT = 0;
   localparam int EV_TOP = 1;

   function automatic bit cfg_used(int idx);
      if (idx >= A_SYNC_BASE) return ((idx - A_SYNC_BASE) % SYNC_STRIDE) <= S_VO_B;
      return (idx <= A_FIELD_HL) || (idx >= A_WIN_T_ST && idx <= A_WIN_B_SP);
   endfunction
endpackage

// File: rtl/vtg_span.sv
module vtg_span #(
   parameter int W = 12
) (
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic [W-1:0] pos,
   output logic         on
);
   always_comb begin
      if (lo <= hi) on = (pos >= lo) && (pos < hi);
      else          on = (pos >= lo) || (pos < hi);
   end
endmodule

// File: rtl/vtg_cfg.sv
module vtg_cfg #(
   parameter int ADDR_W  = 8,
   parameter int N_WORDS = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              load,
   output logic [31:0]       pend_o [N_WORDS],
   output logic [31:0]       act_o  [N_WORDS]
);
   for (genvar i = 0; i < N_WORDS; i++) begin : g_word
      if (vtg_pkg::cfg_used(i)) begin : g_store
         logic [31:0] p_q, a_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_q <= '0;
               a_q <= '0;
            end else begin
               if (wr_en && wr_addr == ADDR_W'(i)) p_q <= wr_data;
               if (load) a_q <= p_q;
            end
         end
         assign pend_o[i] = p_q;
         assign act_o[i]  = a_q;
      end else begin : g_hole
         assign pend_o[i] = '0;
         assign act_o[i]  = '0;
      end
   end
endmodule

// File: rtl/vtg_raster.sv
module vtg_raster #(
   parameter int PIX_W = 12,
   parameter int LIN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PIX_W:0]   line_len,
   input  logic [LIN_W-1:0] field_lines,
   output logic [PIX_W-1:0] pix_o,
   output logic [LIN_W-1:0] line_o,
   output logic             bot_o,
   output logic             sof_o,
   output logic             field_end_o
);
   logic pix_last, line_last;

   assign pix_last    = ({1'b0, pix_o} + (PIX_W+1)'(1)) >= line_len;
   assign line_last   = line_o >= field_lines;
   assign field_end_o = pix_last && line_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_o  <= '0;
         line_o <= LIN_W'(1);
         bot_o  <= 1'b0;
         sof_o  <= 1'b0;
      end else begin
         sof_o <= restart | (run & field_end_o);
         if (restart) begin
            pix_o  <= '0;
            line_o <= LIN_W'(1);
            bot_o  <= 1'b0;
         end else if (run) begin
            if (pix_last) begin
               pix_o <= '0;
               if (line_last) begin
                  line_o <= LIN_W'(1);
                  bot_o  <= ~bot_o;
               end else begin
                  line_o <= line_o + LIN_W'(1);
               end
            end else begin
               pix_o <= pix_o + PIX_W'(1);
            end
         end
      end
   end

   AST_PIX_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_len != '0) |-> ({1'b0, pix_o} < line_len)); // R1
   AST_LINE_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (field_lines != '0) |-> (line_o >= LIN_W'(1) && line_o <= field_lines)); // R2
   AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && field_end_o) |=> (bot_o != $past(bot_o))); // R2
   AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      sof_o |-> (pix_o == '0 && line_o == LIN_W'(1))); // R10
   AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> ($stable(pix_o) && $stable(line_o))); // R12
endmodule

// File: rtl/vtiming_gen.sv
module vtiming_gen #(
   parameter int ADDR_W = 8,
   parameter int PIX_W  = 12,
   parameter int LIN_W  = 11,
   parameter int N_SYNC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_we,
   output logic [31:0]       reg_rdata,
   output logic [PIX_W-1:0]  pix_o,
   output logic [LIN_W-1:0]  line_o,
   output logic              bot_field_o,
   output logic              active_o,
   output logic [N_SYNC-1:0] hsync_o,
   output logic [N_SYNC-1:0] vsync_o,
   output logic              irq_o
);
   import vtg_pkg::*;

   localparam int N_WORDS = A_SYNC_BASE + SYNC_STRIDE * N_SYNC;
   localparam int IDX_W   = $clog2(N_WORDS);
   localparam int KEY_W   = LIN_W + PIX_W;

   if (PIX_W < 1 || PIX_W > 16) begin : g_bad_pix
      $error("PIX_W must lie in 1..16");
   end
   if (LIN_W < 1 || LIN_W > 16) begin : g_bad_lin
      $error("LIN_W must lie in 1..16");
   end
   if (N_SYNC < 1 || N_WORDS > (1 << ADDR_W)) begin : g_bad_map
      $error("N_SYNC does not fit the address space");
   end

   logic [31:0] pend [N_WORDS];
   logic [31:0] act  [N_WORDS];
   logic        restart_q, run, sof, field_end, load, cfg_unused;
   logic [1:0]  status_q, mask_q, ev, st_clr, mk_clr, mk_set;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
      return a == ADDR_W'(idx);
   endfunction

   assign run  = (act[A_MODE] == '0);
   assign load = restart_q | (run & field_end);

   vtg_cfg #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
      .wr_data(reg_wdata), .load(load), .pend_o(pend), .act_o(act));

   vtg_raster #(.PIX_W(PIX_W), .LIN_W(LIN_W)) u_raster (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart_q),
      .line_len(act[A_LINE_LEN][PIX_W:0]), .field_lines(act[A_FIELD_HL][LIN_W:1]),
      .pix_o(pix_o), .line_o(line_o), .bot_o(bot_field_o), .sof_o(sof),
      .field_end_o(field_end));

   assign ev     = !sof ? 2'b00 : (bot_field_o ? 2'b01 : 2'b10);
   assign st_clr = (reg_we && hit(reg_addr, A_STAT_CLR)) ? reg_wdata[1:0] : 2'b00;
   assign mk_clr = (reg_we && hit(reg_addr, A_MASK_CLR)) ? reg_wdata[1:0] : 2'b00;
   assign mk_set = (reg_we && hit(reg_addr, A_MASK_SET)) ? reg_wdata[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         restart_q <= 1'b0;
         status_q  <= '0;
         mask_q    <= '0;
      end else begin
         restart_q <= reg_we && hit(reg_addr, A_RESTART) && reg_wdata[0];
         status_q  <= (status_q & ~st_clr) | ev;
         mask_q    <= (mask_q & ~mk_clr) | mk_set;
      end
   end

   assign irq_o = |(status_q & mask_q);

   always_comb begin
      if (hit(reg_addr, A_STAT) || hit(reg_addr, A_STAT_CLR))
         reg_rdata = {30'b0, status_q};
      else if (hit(reg_addr, A_MASK_CLR) || hit(reg_addr, A_MASK_SET))
         reg_rdata = {30'b0, mask_q};
      else if (reg_addr < ADDR_W'(N_WORDS))
         reg_rdata = pend[reg_addr[IDX_W-1:0]];
      else
         reg_rdata = '0;
   end

   always_comb begin
      cfg_unused = 1'b0;
      for (int j = 0; j < N_WORDS; j++) cfg_unused ^= ^act[j];
   end

   logic [31:0] win_st, win_sp;
   assign win_st   = bot_field_o ? act[A_WIN_B_ST] : act[A_WIN_T_ST];
   assign win_sp   = bot_field_o ? act[A_WIN_B_SP] : act[A_WIN_T_SP];
   assign active_o = (line_o >= win_st[16 +: LIN_W]) && (line_o <= win_sp[16 +: LIN_W]) &&
                     (pix_o >= win_st[PIX_W-1:0]) && (pix_o <= win_sp[PIX_W-1:0]);

   for (genvar s = 0; s < N_SYNC; s++) begin : g_sync
      localparam int B = A_SYNC_BASE + SYNC_STRIDE * s;
      logic [31:0] hw, lw, ow;
      logic [KEY_W-1:0] rise_k, fall_k;
      assign hw     = act[B + S_HORZ];
      assign lw     = bot_field_o ? act[B + S_VL_B] : act[B + S_VL_T];
      assign ow     = bot_field_o ? act[B + S_VO_B] : act[B + S_VO_T];
      assign rise_k = {lw[LIN_W-1:0], ow[PIX_W-1:0]};
      assign fall_k = {lw[16 +: LIN_W], ow[16 +: PIX_W]};
      vtg_span #(.W(PIX_W)) u_h (.lo(hw[PIX_W-1:0]), .hi(hw[16 +: PIX_W]),
                                 .pos(pix_o), .on(hsync_o[s]));
      vtg_span #(.W(KEY_W)) u_v (.lo(rise_k), .hi(fall_k),
                                 .pos({line_o, pix_o}), .on(vsync_o[s]));
   end

   AST_TOP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && !bot_field_o) |=> status_q[EV_TOP]); // R8
   AST_BOT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && bot_field_o) |=> status_q[EV_BOT]); // R8
   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(A_MASK_SET) && reg_wdata[0]) |=> mask_q[0]); // R9
endmodule

// File: tb/sim_vtiming_gen.sv
module sim_vtiming_gen;
   localparam int PIX_W = 12, LIN_W = 11, N_SYNC = 4, ADDR_W = 8;
   localparam int L = 10, NL = 6, FLD = L * NL;

   logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata, rv;
   logic [PIX_W-1:0] pix_o;
   logic [LIN_W-1:0] line_o;
   logic bot_field_o, active_o, irq_o;
   logic [N_SYNC-1:0] hsync_o, vsync_o;
   int n_chk = 0, n_bad = 0, k = 0;
   bit finished = 0;

   int h_st[4] = '{1, 8, 0, 9};
   int h_sp[4] = '{4, 2, 0, 0};
   int rl[2][4] = '{'{1, 6, 0, 3}, '{2, 6, 0, 3}};
   int ro[2][4] = '{'{0, 7, 0, 0}, '{3, 7, 0, 0}};
   int fl[2][4] = '{'{2, 1, 0, 3}, '{3, 1, 0, 3}};
   int fo[2][4] = '{'{0, 7, 0, 5}, '{3, 7, 0, 5}};
   int w_sl[2] = '{2, 3}, w_sp[2] = '{2, 1}, w_el[2] = '{5, 4}, w_ep[2] = '{7, 3};

   always #10 clk = ~clk;

   vtiming_gen #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .LIN_W(LIN_W), .N_SYNC(N_SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata), .pix_o(pix_o), .line_o(line_o), .bot_field_o(bot_field_o),
      .active_o(active_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .irq_o(irq_o));

   task automatic chk(input bit ok, input string req, input string what, input int act_v, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s at k=%0d: got %0d expected %0d", req, what, k, act_v, exp_v);
      end
   endtask

   task automatic eq(input string req, input string what, input int act_v, input int exp_v);
      chk(act_v == exp_v, req, what, act_v, exp_v);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); reg_addr = ADDR_W'(a); reg_wdata = d; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
   endtask
   task automatic drv(input int a, input logic [31:0] d);
      reg_addr = ADDR_W'(a); reg_wdata = d; reg_we = 1'b1;
   endtask
   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = ADDR_W'(a); #1; d = reg_rdata;
   endtask
   task automatic adv(input int t);
      while (k < t) begin @(negedge clk); k++; end
   endtask
   task automatic restart_sync();
      wr(3, 1); k = -1; adv(0);
   endtask

   function automatic bit span(input int s, input int e, input int x);
      return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
   endfunction

   task automatic cfg_all();
      wr(1, L); wr(2, 2 * NL);
      for (int f = 0; f < 2; f++) begin
         wr(4 + 2 * f, (w_sl[f] << 16) | w_sp[f]);
         wr(5 + 2 * f, (w_el[f] << 16) | w_ep[f]);
      end
      for (int s = 0; s < 4; s++) begin
         wr(16 + 8 * s, (h_sp[s] << 16) | h_st[s]);
         for (int f = 0; f < 2; f++) begin
            wr(17 + 8 * s + f, (fl[f][s] << 16) | rl[f][s]);
            wr(19 + 8 * s + f, (fo[f][s] << 16) | ro[f][s]);
         end
      end
      wr(0, 0);
   endtask

   task automatic t_reset();
      rd(1, rv);
      eq("R1", "reset pixel", int'(pix_o), 0);
      eq("R1", "reset line", int'(line_o), 1);
      eq("R2", "reset field", int'(bot_field_o), 0);
      eq("R3", "reset active", int'(active_o), 0);
      eq("R4", "reset hsync", int'(hsync_o), 0);
      eq("R6", "reset vsync", int'(vsync_o), 0);
      eq("R9", "reset irq", int'(irq_o), 0);
      eq("R11", "reset line length readback", int'(rv), 0);
   endtask

   task automatic t_scan();
      cfg_all();
      rd(1, rv);
      eq("R11", "pending readback", int'(rv), L);
      restart_sync();
      for (int c = 0; c < 2 * FLD + 5; c++) begin
         adv(c);
         begin
            int f = (c / FLD) % 2, ln = 1 + (c % FLD) / L, p = c % L, key = ln * 65536 + p;
            bit ea = ln >= w_sl[f] && ln <= w_el[f] && p >= w_sp[f] && p <= w_ep[f];
            eq("R1", "pixel", int'(pix_o), p);
            eq("R1", "line", int'(line_o), ln);
            eq("R2", "field", int'(bot_field_o), f);
            eq("R3", "active window", int'(active_o), int'(ea));
            eq("R4", "hsync0", int'(hsync_o[0]), int'(span(h_st[0], h_sp[0], p)));
            eq("R5", "hsync1 wrapped", int'(hsync_o[1]), int'(span(h_st[1], h_sp[1], p)));
            eq("R4", "hsync2 empty", int'(hsync_o[2]), 0);
            eq("R5", "hsync3 last pixel", int'(hsync_o[3]), int'(p == 9));
            for (int s = 0; s < 4; s++)
               eq(s == 0 ? "R7" : "R6", $sformatf("vsync%0d", s), int'(vsync_o[s]),
                  int'(span(rl[f][s] * 65536 + ro[f][s], fl[f][s] * 65536 + fo[f][s], key)));
         end
      end
   endtask

   task automatic t_shadow();
      restart_sync();
      adv(5); drv(1, 8);
      adv(6); reg_we = 1'b0;
      rd(1, rv);
      eq("R11", "new length readback", int'(rv), 8);
      adv(9);
      eq("R11", "old length still used", int'(pix_o), 9);
      adv(FLD);
      eq("R11", "field start pixel", int'(pix_o), 0);
      eq("R11", "field start line", int'(line_o), 1);
      adv(FLD + 7);
      eq("R11", "new length last pixel", int'(pix_o), 7);
      adv(FLD + 8);
      eq("R11", "new length wrap line", int'(line_o), 2);
      eq("R11", "new length wrap pixel", int'(pix_o), 0);
      wr(1, L);
   endtask

   task automatic t_halt();
      restart_sync();
      adv(2); drv(0, 1);
      adv(3); reg_we = 1'b0;
      adv(FLD - 1);
      eq("R12", "still running pixel", int'(pix_o), L - 1);
      eq("R12", "still running line", int'(line_o), NL);
      adv(FLD + 6);
      eq("R12", "halted pixel", int'(pix_o), 0);
      eq("R12", "halted line", int'(line_o), 1);
   endtask

   task automatic t_irq();
      wr(9, 3); wr(10, 3);
      rd(8, rv);
      eq("R8", "status cleared", int'(rv), 0);
      wr(11, 2);
      rd(10, rv);
      eq("R9", "mask set readback", int'(rv), 2);
      eq("R9", "irq with empty status", int'(irq_o), 0);
      wr(0, 0);
      repeat (3) @(negedge clk);
      eq("R11", "mode waits for restart", int'(pix_o), 0);
      restart_sync();
      rd(8, rv);
      eq("R8", "status before event", int'(rv), 0);
      adv(1); rd(8, rv);
      eq("R8", "top event bit", int'(rv), 2);
      eq("R9", "irq on masked top", int'(irq_o), 1);
      eq("R10", "restart line", int'(line_o), 1);
      adv(FLD + 1); rd(8, rv);
      eq("R8", "bottom event bit", int'(rv), 3);
      drv(9, 3);
      adv(FLD + 2); reg_we = 1'b0; rd(8, rv);
      eq("R8", "write one to clear", int'(rv), 0);
      eq("R9", "irq after clear", int'(irq_o), 0);
      adv(2 * FLD); drv(9, 2);
      adv(2 * FLD + 1); reg_we = 1'b0; rd(8, rv);
      eq("R8", "event beats clear", int'(rv), 2);
      drv(10, 2);
      adv(2 * FLD + 2); reg_we = 1'b0; rd(10, rv);
      eq("R9", "mask clear readback", int'(rv), 0);
      eq("R9", "irq after mask clear", int'(irq_o), 0);
      drv(11, 1);
      adv(2 * FLD + 3); reg_we = 1'b0;
      eq("R9", "irq top status bottom mask", int'(irq_o), 0);
      adv(3 * FLD + 1);
      eq("R9", "irq on masked bottom", int'(irq_o), 1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_scan();
      t_shadow();
      t_halt();
      t_irq();
      summary();
   end
endmodule